// File: doc/BRIEF.md
# Exposure and Frame-Rate Sequencer

This block paces the frames of a line-based image sensor. It counts incoming line-complete strobes into a frame. For every line it issues a row-sample strobe, which names the row being read. It also issues a row-reset strobe, which names the row that must begin integrating now so that it is sampled exactly the programmed number of lines later. Software programs the block through a byte-wide register port. It sets the exposure in whole lines, picks one of eight frame rates, and chooses between continuous video and one-shot capture.

Exposure and frame-rate changes are never applied mid-frame. Software writes the new values into shadow registers and then sets a self-clearing command bit. That bit reads back as busy until the next frame boundary has copied the value into the active state. A slower frame rate is produced by making the frame longer in lines, so the line strobe can keep a fixed period. In one-shot mode, each arm command yields exactly one frame of valid output, after which the block idles until armed again.

Top module: `expo_frame_seq`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the exposure registers (address 1 low byte, address 2 high byte) read 0x01 and 0x00, the active exposure is 1 line, the active frame length is BASE_LINES and frame_valid is low.
- R2: Each line_done pulse produces a one-cycle row_sample strobe on the next cycle, when the frame is valid. sample_row gives the line index within the frame, which counts 0 to frame_lines-1 and then wraps. The frame boundary is the line_done that ends index frame_lines-1.
- R3: Each line_done pulse produces a one-cycle row_reset strobe on the next cycle, with reset_row equal to (sample index + active exposure) modulo the active frame length.
- R4: Control bit 0 selects the mode: 0 is continuous video and 1 is single-frame capture. In video mode frame_valid goes high at the first frame boundary and stays high.
- R5: Writing 1 to control bit 2 arms the shadow exposure. Control bit 2 reads 1 until the next frame boundary loads the shadow into exposure_lines, and then reads 0. This applies in video mode.
- R6: An exposure of 0 is loaded as 1. An exposure above the new frame length is loaded as that frame length.
- R7: Control bits [6:4] hold a shadow frame-rate code with no effect until control bit 7 is written as 1. Bit 7 then reads 1 until the next boundary, where frame_lines becomes BASE_LINES times 1, 2, 3, 6, 7.5, 10, 15 or 30 for codes 0 to 7. With BASE_LINES=1100 these give 30, 15, 10, 5, 4, 3, 2 and 1 frames per second.
- R8: In single-frame mode, writing control bits 0 and 2 both as 1 arms one capture. frame_valid is high for exactly the frame that follows the next boundary, and is low before and after it. Control bit 2 reads 1 from the arm write until that frame has ended. No row_sample strobe occurs while frame_valid is low.
- R9: Writes to addresses 1 and 2 are read back unchanged and do not alter exposure_lines until armed.
- R10: frame_start pulses for one cycle on the cycle after a boundary, only when the new frame is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_done | input | 1 | One-cycle strobe at the end of each line time |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register address (0 control, 1 exposure low, 2 exposure high) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| frame_start | output | 1 | One-cycle pulse at the start of a valid frame |
| frame_valid | output | 1 | High for the duration of a valid frame |
| row_reset | output | 1 | Row-reset strobe |
| reset_row | output | LINE_W | Row to reset |
| row_sample | output | 1 | Row-sample strobe |
| sample_row | output | LINE_W | Row to sample |
| exposure_lines | output | LINE_W | Active exposure in lines |
| frame_lines | output | LINE_W | Active frame length in lines |

## Verification
The line counter is driven through frames of several lengths: the base length and all seven stretched lengths. This separates a wrap at the wrong index from a wrong length table entry. Exposures of 1, 3, 0 and an over-range value are applied. The over-range value exposes modulo errors in the reset row and missing clamps at both ends. Command bits are written and then read back before and after a boundary, which shows whether a change leaked through early or never cleared. Single-frame capture is run through an idle frame, the armed frame and the frames after it, which separates one-shot behaviour from a free-running frame_valid.

// File: rtl/expo_seq_pkg.sv
package expo_seq_pkg;

   localparam int CTL_MODE   = 0;
   localparam int CTL_ARM    = 2;
   localparam int CTL_RATE   = 4;
   localparam int CTL_COMMIT = 7;
   localparam int RATE_W     = 3;

   typedef enum logic [1:0] {
      CAP_IDLE  = 2'd0,
      CAP_ARMED = 2'd1,
      CAP_RUN   = 2'd2
   } cap_state_e;

   // frame length for a rate code, as base * half-steps / 2
   function automatic int unsigned rate_lines(input logic [RATE_W-1:0] code,
                                              input int unsigned base);
      int unsigned halves;
      case (code)
         3'd0:    halves = 2;
         3'd1:    halves = 4;
         3'd2:    halves = 6;
         3'd3:    halves = 12;
         3'd4:    halves = 15;
         3'd5:    halves = 20;
         3'd6:    halves = 30;
         default: halves = 60;
      endcase
      return (base * halves) / 2;
   endfunction

endpackage

// File: rtl/expo_seq_regs.sv
module expo_seq_regs
   import expo_seq_pkg::*;
#(
   parameter int LINE_W = 16,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic                 frame_edge,
   input  logic                 cap_busy,
   output logic [DATA_W-1:0]    rdata,
   output logic                 mode,
   output logic [RATE_W-1:0]    rate_sh,
   output logic [LINE_W-1:0]    exp_sh,
   output logic                 arm_cap,
   output logic                 exp_pend,
   output logic                 rate_pend
);

   localparam int HI_W = LINE_W - DATA_W;
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_EXL = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_EXH = ADDR_W'(2);
   localparam logic [DATA_W-1:0] STAT_MASK =
      (DATA_W'(1) << CTL_ARM) | (DATA_W'(1) << CTL_COMMIT);

   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must hold the control byte");
      end
      if (HI_W < 1 || HI_W > DATA_W) begin : g_bad_line
         $error("LINE_W must fit in two data words");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must reach three registers");
      end
   endgenerate

   logic [DATA_W-1:0] ctl_q;
   logic              wr_ctl;
   logic              status_arm;

   assign wr_ctl  = wr && (addr == A_CTL);
   assign arm_cap = wr_ctl && wdata[CTL_ARM] && wdata[CTL_MODE];
   assign mode    = ctl_q[CTL_MODE];
   assign rate_sh = ctl_q[CTL_RATE +: RATE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q     <= '0;
         exp_sh    <= LINE_W'(1);
         exp_pend  <= 1'b0;
         rate_pend <= 1'b0;
      end else begin
         if (wr_ctl) ctl_q <= wdata & ~STAT_MASK;
         if (wr && addr == A_EXL) exp_sh[DATA_W-1:0] <= wdata;
         if (wr && addr == A_EXH) exp_sh[LINE_W-1:DATA_W] <= wdata[HI_W-1:0];
         if (wr_ctl && wdata[CTL_ARM]) exp_pend <= 1'b1;
         else if (frame_edge)          exp_pend <= 1'b0;
         if (wr_ctl && wdata[CTL_COMMIT]) rate_pend <= 1'b1;
         else if (frame_edge)             rate_pend <= 1'b0;
      end
   end

   assign status_arm = mode ? cap_busy : exp_pend;

   always_comb begin
      rdata = '0;
      case (addr)
         A_CTL: begin
            rdata = ctl_q;
            rdata[CTL_ARM]    = status_arm;
            rdata[CTL_COMMIT] = rate_pend;
         end
         A_EXL:   rdata = exp_sh[DATA_W-1:0];
         A_EXH:   rdata = DATA_W'(exp_sh[LINE_W-1:DATA_W]);
         default: rdata = '0;
      endcase
   end

   // R7
   rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_pend && !frame_edge) |=> rate_pend);

   // R5
   exp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_pend && !frame_edge) |=> exp_pend);

endmodule

// File: rtl/expo_seq_frame.sv
module expo_seq_frame
   import expo_seq_pkg::*;
#(
   parameter int LINE_W     = 16,
   parameter int BASE_LINES = 1100
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 line_done,
   input  logic                 mode,
   input  logic [RATE_W-1:0]    rate_sh,
   input  logic [LINE_W-1:0]    exp_sh,
   input  logic                 exp_pend,
   input  logic                 rate_pend,
   input  logic                 arm_cap,
   output logic                 frame_edge,
   output logic [LINE_W-1:0]    line_cnt,
   output logic [LINE_W-1:0]    lines_cur,
   output logic [LINE_W-1:0]    exp_cur,
   output logic                 frame_valid,
   output logic                 frame_start,
   output logic                 cap_busy
);

   localparam longint MAX_LINES = longint'(BASE_LINES) * 30;

   generate
      if (BASE_LINES < 2 || (BASE_LINES % 2) != 0) begin : g_bad_base
         $error("BASE_LINES must be even and at least 2");
      end
      if (MAX_LINES >= (longint'(1) << LINE_W)) begin : g_bad_width
         $error("LINE_W too narrow for the slowest frame rate");
      end
   endgenerate

   cap_state_e          cap_q;
   logic [LINE_W-1:0]   lines_nxt;
   logic [LINE_W-1:0]   exp_src;
   logic [LINE_W-1:0]   exp_nxt;
   logic                valid_nxt;

   assign frame_edge = line_done && (line_cnt == lines_cur - LINE_W'(1));
   assign lines_nxt  = rate_pend ? LINE_W'(rate_lines(rate_sh, BASE_LINES)) : lines_cur;
   assign exp_src    = exp_pend ? exp_sh : exp_cur;
   assign valid_nxt  = mode ? (cap_q == CAP_ARMED) : 1'b1;
   assign cap_busy   = (cap_q != CAP_IDLE);

   always_comb begin
      if (exp_src == '0)            exp_nxt = LINE_W'(1);
      else if (exp_src > lines_nxt) exp_nxt = lines_nxt;
      else                          exp_nxt = exp_src;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_cnt    <= '0;
         lines_cur   <= LINE_W'(BASE_LINES);
         exp_cur     <= LINE_W'(1);
         frame_valid <= 1'b0;
         frame_start <= 1'b0;
      end else begin
         frame_start <= frame_edge && valid_nxt;
         if (frame_edge) begin
            line_cnt    <= '0;
            lines_cur   <= lines_nxt;
            exp_cur     <= exp_nxt;
            frame_valid <= valid_nxt;
         end else if (line_done) begin
            line_cnt <= line_cnt + LINE_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= CAP_IDLE;
      end else if (!mode && !arm_cap) begin
         cap_q <= CAP_IDLE;
      end else if (frame_edge) begin
         case (cap_q)
            CAP_ARMED: cap_q <= CAP_RUN;
            CAP_RUN:   cap_q <= CAP_IDLE;
            default:   cap_q <= arm_cap ? CAP_ARMED : CAP_IDLE;
         endcase
      end else if (arm_cap && cap_q == CAP_IDLE) begin
         cap_q <= CAP_ARMED;
      end
   end

   // R2
   line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_cnt < lines_cur);

   // R6
   exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_cur >= LINE_W'(1)) && (exp_cur <= lines_cur));

   // R7
   lines_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_edge |=> $stable(lines_cur));

   // R10
   start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> frame_valid);

   // R8
   one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode && cap_q == CAP_RUN && frame_edge && !arm_cap) |=> !frame_valid);

endmodule

// File: rtl/expo_seq_rows.sv
module expo_seq_rows #(
   parameter int LINE_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 line_done,
   input  logic [LINE_W-1:0]    line_cnt,
   input  logic [LINE_W-1:0]    lines_cur,
   input  logic [LINE_W-1:0]    exp_cur,
   input  logic                 frame_valid,
   output logic                 row_reset,
   output logic [LINE_W-1:0]    reset_row,
   output logic                 row_sample,
   output logic [LINE_W-1:0]    sample_row
);

   logic [LINE_W:0]   ahead;
   logic [LINE_W-1:0] ahead_mod;

   assign ahead = {1'b0, line_cnt} + {1'b0, exp_cur};

   always_comb begin
      if (ahead >= {1'b0, lines_cur}) ahead_mod = LINE_W'(ahead - {1'b0, lines_cur});
      else                            ahead_mod = ahead[LINE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_reset  <= 1'b0;
         row_sample <= 1'b0;
         reset_row  <= '0;
         sample_row <= '0;
      end else begin
         row_reset  <= line_done;
         row_sample <= line_done && frame_valid;
         if (line_done) begin
            reset_row  <= ahead_mod;
            sample_row <= line_cnt;
         end
      end
   end

   // R2
   sample_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_sample |-> row_reset);

   // R3
   reset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |=> (reset_row < $past(lines_cur)));

endmodule

// File: rtl/expo_frame_seq.sv
module expo_frame_seq
   import expo_seq_pkg::*;
#(
   parameter int LINE_W     = 16,
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 2,
   parameter int BASE_LINES = 1100
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 line_done,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   output logic                 frame_start,
   output logic                 frame_valid,
   output logic                 row_reset,
   output logic [LINE_W-1:0]    reset_row,
   output logic                 row_sample,
   output logic [LINE_W-1:0]    sample_row,
   output logic [LINE_W-1:0]    exposure_lines,
   output logic [LINE_W-1:0]    frame_lines
);

   logic                mode;
   logic [RATE_W-1:0]   rate_sh;
   logic [LINE_W-1:0]   exp_sh;
   logic                arm_cap;
   logic                exp_pend;
   logic                rate_pend;
   logic                frame_edge;
   logic                cap_busy;
   logic [LINE_W-1:0]   line_cnt;

   expo_seq_regs #(.LINE_W(LINE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (reg_wr),
      .addr       (reg_addr),
      .wdata      (reg_wdata),
      .frame_edge (frame_edge),
      .cap_busy   (cap_busy),
      .rdata      (reg_rdata),
      .mode       (mode),
      .rate_sh    (rate_sh),
      .exp_sh     (exp_sh),
      .arm_cap    (arm_cap),
      .exp_pend   (exp_pend),
      .rate_pend  (rate_pend)
   );

   expo_seq_frame #(.LINE_W(LINE_W), .BASE_LINES(BASE_LINES)) u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_done   (line_done),
      .mode        (mode),
      .rate_sh     (rate_sh),
      .exp_sh      (exp_sh),
      .exp_pend    (exp_pend),
      .rate_pend   (rate_pend),
      .arm_cap     (arm_cap),
      .frame_edge  (frame_edge),
      .line_cnt    (line_cnt),
      .lines_cur   (frame_lines),
      .exp_cur     (exposure_lines),
      .frame_valid (frame_valid),
      .frame_start (frame_start),
      .cap_busy    (cap_busy)
   );

   expo_seq_rows #(.LINE_W(LINE_W)) u_rows (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_done   (line_done),
      .line_cnt    (line_cnt),
      .lines_cur   (frame_lines),
      .exp_cur     (exposure_lines),
      .frame_valid (frame_valid),
      .row_reset   (row_reset),
      .reset_row   (reset_row),
      .row_sample  (row_sample),
      .sample_row  (sample_row)
   );

endmodule

// File: tb/tb_expo_frame_seq.sv
module tb_expo_frame_seq;

   localparam int LW   = 16;
   localparam int BASE = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          line_done = 1'b0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [7:0]    reg_wdata = '0;
   logic [7:0]    reg_rdata;
   logic          frame_start, frame_valid, row_reset, row_sample;
   logic [LW-1:0] reset_row, sample_row, exposure_lines, frame_lines;

   always #5 clk = ~clk;

   expo_frame_seq #(.LINE_W(LW), .DATA_W(8), .ADDR_W(2), .BASE_LINES(BASE)) dut (
      .clk(clk), .rst_n(rst_n), .line_done(line_done),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .frame_start(frame_start), .frame_valid(frame_valid),
      .row_reset(row_reset), .reset_row(reset_row),
      .row_sample(row_sample), .sample_row(sample_row),
      .exposure_lines(exposure_lines), .frame_lines(frame_lines)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      bit smp;
      int srow;
      int rrow;
      bit fst;
   } item_t;
   item_t sb[$];

   // reference state, built from the requirements
   int m_cnt = 0, m_L = BASE, m_exp = 1, m_esh = 1, m_cap = 0;
   bit m_valid = 0, m_mode = 0, m_pe = 0, m_pr = 0;
   int m_rsh = 0;
   int m_ctl = 0;

   function automatic int len_of(int code);
      case (code)
         0: return BASE;
         1: return BASE * 2;
         2: return BASE * 3;
         3: return BASE * 6;
         4: return (BASE * 15) / 2;
         5: return BASE * 10;
         6: return BASE * 15;
         default: return BASE * 30;
      endcase
   endfunction

   function automatic int ctl_expect();
      int busy;
      busy = m_mode ? (m_cap != 0) : m_pe;
      return (m_ctl & 8'h7B) | (busy << 2) | (int'(m_pr) << 7);
   endfunction

   task automatic check(string req, int act, int exp_v);
      n_chk++;
      if (act != exp_v) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   // driver: one line strobe, expected outputs pushed to the scoreboard
   task automatic line();
      item_t e;
      int nl, src;
      e.smp  = m_valid;
      e.srow = m_cnt;
      e.rrow = (m_cnt + m_exp) % m_L;
      e.fst  = 0;
      if (m_cnt == m_L - 1) begin
         nl  = m_pr ? len_of(m_rsh) : m_L;
         src = m_pe ? m_esh : m_exp;
         m_exp = (src == 0) ? 1 : ((src > nl) ? nl : src);
         m_L = nl;
         m_valid = m_mode ? (m_cap == 1) : 1'b1;
         if (m_mode) m_cap = (m_cap == 1) ? 2 : 0;
         m_pe = 0;
         m_pr = 0;
         m_cnt = 0;
         e.fst = m_valid;
      end else begin
         m_cnt++;
      end
      @(negedge clk);
      sb.push_back(e);
      line_done = 1'b1;
      @(negedge clk);
      line_done = 1'b0;
   endtask

   task automatic lines(int n);
      for (int i = 0; i < n; i++) line();
   endtask

   task automatic to_boundary();
      lines(m_L - m_cnt);
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_addr = 2'(a);
      reg_wdata = 8'(d);
      @(negedge clk);
      reg_wr = 1'b0;
      if (a == 0) begin
         m_ctl = d;
         m_mode = d[0];
         m_rsh = (d >> 4) & 7;
         if (d[2]) begin
            m_pe = 1;
            if (d[0] && m_cap == 0) m_cap = 1;
         end
         if (d[7]) m_pr = 1;
      end else if (a == 1) begin
         m_esh = (m_esh & 32'hFF00) | (d & 8'hFF);
      end else if (a == 2) begin
         m_esh = (m_esh & 32'h00FF) | ((d & 8'hFF) << 8);
      end
   endtask

   task automatic rd(int a, output int v);
      @(negedge clk);
      reg_addr = 2'(a);
      #1;
      v = int'(reg_rdata);
   endtask

   // monitor: pops the scoreboard on every strobe cycle
   initial begin
      forever begin
         bit f;
         item_t e;
         @(posedge clk);
         f = line_done;
         @(negedge clk);
         if (f) begin
            if (sb.size() == 0) begin
               check("R2 scoreboard empty", 1, 0);
            end else begin
               e = sb.pop_front();
               check("R2 row_sample", int'(row_sample), int'(e.smp));
               check("R2 sample_row", int'(sample_row), e.srow);
               check("R3 row_reset", int'(row_reset), 1);
               check("R3 reset_row", int'(reset_row), e.rrow);
               check("R10 frame_start", int'(frame_start), int'(e.fst));
            end
         end else if (rst_n && (row_sample || row_reset || frame_start)) begin
            check("R2 strobe without line", 1, 0);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(0, v); check("R1 control", v, 0);
      rd(1, v); check("R1 exp low", v, 1);
      rd(2, v); check("R1 exp high", v, 0);
      check("R1 exposure_lines", int'(exposure_lines), 1);
      check("R1 frame_lines", int'(frame_lines), BASE);
      check("R1 frame_valid", int'(frame_valid), 0);

      // R4 video mode: first boundary raises frame_valid
      lines(BASE + 5);
      check("R4 frame_valid video", int'(frame_valid), 1);

      // R9 shadow exposure has no effect before arming
      wr(1, 3); wr(2, 0);
      rd(1, v); check("R9 exp low readback", v, 3);
      lines(BASE);
      check("R9 exposure unchanged", int'(exposure_lines), 1);

      // R5 arm in video mode
      wr(0, 8'h04);
      rd(0, v); check("R5 busy after arm", v, ctl_expect());
      check("R5 busy bit set", (v >> 2) & 1, 1);
      check("R5 exposure before boundary", int'(exposure_lines), 1);
      to_boundary();
      check("R5 exposure applied", int'(exposure_lines), 3);
      rd(0, v); check("R5 busy cleared", (v >> 2) & 1, 0);
      lines(BASE + 2);

      // R6 clamps
      wr(1, 0); wr(2, 0); wr(0, 8'h04);
      to_boundary();
      check("R6 zero clamps to 1", int'(exposure_lines), 1);
      wr(1, 0); wr(2, 1); wr(0, 8'h04);
      rd(2, v); check("R9 exp high readback", v, 1);
      to_boundary();
      check("R6 clamp to frame length", int'(exposure_lines), BASE);
      lines(3);

      // R7 latent rate field without commit
      wr(0, 8'h30);
      rd(0, v); check("R7 rate field readback", v, 8'h30);
      to_boundary();
      check("R7 no commit no change", int'(frame_lines), BASE);

      // R7 every rate code
      for (int c = 1; c < 8; c++) begin
         wr(0, 8'h80 | (c << 4));
         rd(0, v); check("R7 commit busy", (v >> 7) & 1, 1);
         to_boundary();
         check("R7 frame_lines", int'(frame_lines), len_of(c));
         rd(0, v); check("R7 commit cleared", (v >> 7) & 1, 0);
      end
      wr(0, 8'h80);
      to_boundary();
      check("R7 back to base", int'(frame_lines), BASE);

      // R8 single-frame capture
      wr(0, 8'h01);
      to_boundary();
      check("R8 idle valid low", int'(frame_valid), 0);
      lines(BASE);
      check("R8 still idle", int'(frame_valid), 0);
      wr(0, 8'h05);
      rd(0, v); check("R8 busy after arm", (v >> 2) & 1, 1);
      to_boundary();
      check("R8 capture frame valid", int'(frame_valid), 1);
      rd(0, v); check("R8 busy during frame", (v >> 2) & 1, 1);
      to_boundary();
      check("R8 valid drops after one frame", int'(frame_valid), 0);
      rd(0, v); check("R8 busy cleared", (v >> 2) & 1, 0);
      lines(BASE + 1);
      check("R8 stays idle", int'(frame_valid), 0);

      repeat (4) @(negedge clk);
      check("R2 scoreboard drained", sb.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule